// File: doc/BRIEF.md
# Transceiver Reset and Link Supervision Controller

This block sequences the internal reset and the link supervision of a copper gigabit transceiver core. The host reuses a single disable pin as a reset request. While that pin is high, or while supply power is not yet good, the core is held in reset. When the pin is low and power is good, the controller waits out an initialisation interval and then issues a one-cycle auto-negotiation start pulse.

Once negotiation is running, the link comes up when the negotiation-done flag arrives. If the bypass enable is set and negotiation has not finished when the bypass timer expires, the link comes up anyway, and a status flag records which of the two routes raised it. While the link is up, an idle-symbol watchdog runs. When no idle-seen pulse arrives for a full watchdog period, the link is dropped, a lock-lost flag is raised and negotiation restarts.

All periods are parameters in clock cycles. The pin input is asynchronous and passes through a two-flop synchroniser. The other inputs belong to the block's clock domain.

Top module: `link_supervisor`

## Requirements
- R1: After the synchronous reset, and for as long as the synchronised disable pin is high, `core_rst_o` is 1 and `an_start_o`, `link_up_o`, `lock_lost_o` and `bypass_stat_o` are 0.
- R2: A rising edge on `dis_pin_i` sets `core_rst_o` high and brings `link_up_o` low exactly 3 clock edges later (2 synchroniser stages plus the state register). Entering reset clears `bypass_stat_o`.
- R3: With power good, a falling edge on `dis_pin_i` produces `an_start_o` exactly INIT_CYC+3 clock edges later. The pulse is exactly one cycle wide.
- R4: `pwr_good_i` low forces `core_rst_o` high from the next clock edge. When `pwr_good_i` rises with the pin already low, `an_start_o` follows exactly INIT_CYC+1 edges later.
- R5: While negotiation is in progress, `neg_done_i` high raises `link_up_o` at the next edge with `bypass_stat_o` = 0. If the bypass timer expires in the same cycle, `neg_done_i` wins.
- R6: With `bypass_en_i` = 1 and no `neg_done_i`, `link_up_o` rises exactly BYPASS_CYC edges after the edge that raised `an_start_o`, with `bypass_stat_o` = 1.
- R7: With `bypass_en_i` = 0, the link never comes up without `neg_done_i`, however long negotiation lasts.
- R8: While the link is up, if no `idle_seen_i` pulse is sampled for IDLE_CYC consecutive edges, then at that edge `link_up_o` falls, `lock_lost_o` rises, and `an_start_o` pulses to restart negotiation.
- R9: Each sampled `idle_seen_i` pulse restarts the watchdog. A silence of at most IDLE_CYC-1 edges after a pulse leaves the link up.
- R10: `lock_lost_o` stays high until the link next comes up or the core enters reset, and is 0 whenever `link_up_o` rises.
- R11: `neg_done_i` is ignored outside negotiation. Holding it high during the initialisation interval does not raise `link_up_o` and does not shift the timing of `an_start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| dis_pin_i | input | 1 | Asynchronous host disable/reset pin; high or open means reset |
| pwr_good_i | input | 1 | Supply power is within range |
| idle_seen_i | input | 1 | One-cycle pulse per received idle pattern |
| neg_done_i | input | 1 | Serial-side negotiation completed |
| bypass_en_i | input | 1 | Allow link-up on bypass timeout |
| core_rst_o | output | 1 | Reset to the transceiver core |
| an_start_o | output | 1 | One-cycle auto-negotiation start pulse |
| link_up_o | output | 1 | Link is up |
| lock_lost_o | output | 1 | Link was dropped by the idle watchdog |
| bypass_stat_o | output | 1 | 1 = link raised by the bypass timer, 0 = by completed negotiation |

## Verification
The idle watchdog is exercised with silences of 1, 6, 11, 12 and 13 cycles after an idle pulse. This separates an off-by-one in the watchdog limit from a correct expiry, and the 13-cycle case confirms that the restart pulse lasts only one cycle. Start latency is measured in three situations: from a pin fall, from a power-good rise, and with `neg_done_i` held during initialisation. Each of these must land on an exact edge count, which exposes synchroniser depth, interval length and premature link-up. The link is raised once through completed negotiation, once through the bypass timer, and once not at all with bypass disabled, so the route flag and the enable are each told apart.

// File: rtl/lsup_pkg.sv
package lsup_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_INIT = 2'd1,
        ST_NEG  = 2'd2,
        ST_LINK = 2'd3
    } lsup_state_t;

    typedef struct packed {
        logic lost;
        logic byp;
    } lsup_flags_t;

    // counter width able to hold values 0..limit
    function automatic int lsup_cnt_w(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    // next-state rule; hold has priority over every timer or flag
    function automatic lsup_state_t lsup_next(
        input lsup_state_t cur,
        input logic        hold,
        input logic        init_done,
        input logic        neg_done,
        input logic        byp_done,
        input logic        idle_done
    );
        lsup_state_t n;
        n = cur;
        if (hold) begin
            n = ST_HOLD;
        end else begin
            case (cur)
                ST_HOLD: n = ST_INIT;
                ST_INIT: if (init_done) n = ST_NEG;
                ST_NEG:  if (neg_done || byp_done) n = ST_LINK;
                ST_LINK: if (idle_done) n = ST_NEG;
                default: n = ST_HOLD;
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/lsup_sync.sv
module lsup_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lsup_timer.sv
module lsup_timer
    import lsup_pkg::*;
#(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic done
);
    localparam int W = lsup_cnt_w(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run && (cnt != LAST)) begin
            cnt <= cnt + W'(1);
        end
    end

    assign done = run && !clr && (cnt == LAST);
endmodule

// File: rtl/link_supervisor.sv
module link_supervisor
    import lsup_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int INIT_CYC    = 30000000,
    parameter int IDLE_CYC    = 100000,
    parameter int BYPASS_CYC  = 20000000
) (
    input  logic clk,
    input  logic rst,
    input  logic dis_pin_i,
    input  logic pwr_good_i,
    input  logic idle_seen_i,
    input  logic neg_done_i,
    input  logic bypass_en_i,
    output logic core_rst_o,
    output logic an_start_o,
    output logic link_up_o,
    output logic lock_lost_o,
    output logic bypass_stat_o
);
    lsup_state_t state, nxt;
    lsup_flags_t flags;
    logic        pin_s;
    logic        hold;
    logic        init_done, byp_done, idle_done;
    logic        an_q;

    // pin is asynchronous; resets to the "held" level, as if open
    lsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
        .clk (clk),
        .rst (rst),
        .d   (dis_pin_i),
        .q   (pin_s)
    );

    lsup_timer #(.LIMIT(INIT_CYC)) u_init_tmr (
        .clk  (clk),
        .rst  (rst),
        .clr  (state != ST_INIT),
        .run  (1'b1),
        .done (init_done)
    );

    lsup_timer #(.LIMIT(BYPASS_CYC)) u_byp_tmr (
        .clk  (clk),
        .rst  (rst),
        .clr  (state != ST_NEG),
        .run  (bypass_en_i),
        .done (byp_done)
    );

    lsup_timer #(.LIMIT(IDLE_CYC)) u_idle_tmr (
        .clk  (clk),
        .rst  (rst),
        .clr  ((state != ST_LINK) || idle_seen_i),
        .run  (1'b1),
        .done (idle_done)
    );

    assign hold = pin_s || !pwr_good_i;

    always_comb begin
        nxt = lsup_next(state, hold, init_done, neg_done_i, byp_done, idle_done);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HOLD;
            an_q  <= 1'b0;
            flags <= '0;
        end else begin
            state <= nxt;
            an_q  <= (nxt == ST_NEG) && (state != ST_NEG);
            if (nxt == ST_HOLD) begin
                flags <= '0;
            end else if ((state == ST_LINK) && (nxt == ST_NEG)) begin
                flags.lost <= 1'b1;
            end else if ((state == ST_NEG) && (nxt == ST_LINK)) begin
                flags.lost <= 1'b0;
                flags.byp  <= !neg_done_i;
            end
        end
    end

    assign core_rst_o    = (state == ST_HOLD);
    assign link_up_o     = (state == ST_LINK);
    assign an_start_o    = an_q;
    assign lock_lost_o   = flags.lost;
    assign bypass_stat_o = flags.byp;
endmodule

// File: rtl/link_supervisor_check.sv
module link_supervisor_check
    import lsup_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        pin_s,
    input lsup_state_t state,
    input logic        pwr_good_i,
    input logic        neg_done_i,
    input logic        bypass_en_i,
    input logic        core_rst_o,
    input logic        an_start_o,
    input logic        link_up_o,
    input logic        lock_lost_o,
    input logic        bypass_stat_o
);
    // R1, R2: a held pin forces reset and drops the link on the next edge
    a_r2_pin_drops_link: assert property (@(posedge clk) disable iff (rst)
        pin_s |=> (core_rst_o && !link_up_o));

    // R3: start request is a single-cycle pulse
    a_r3_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
        an_start_o |=> !an_start_o);

    // R4: power not good forces reset
    a_r4_pg_low_reset: assert property (@(posedge clk) disable iff (rst)
        !pwr_good_i |=> core_rst_o);

    // R5: negotiation done raises the link with the route flag clear
    a_r5_done_links: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_NEG) && neg_done_i && pwr_good_i && !pin_s)
        |=> (link_up_o && !bypass_stat_o));

    // R6, R7: a bypass link-up needs the enable
    a_r6_bypass_needs_enable: assert property (@(posedge clk) disable iff (rst)
        ($rose(link_up_o) && bypass_stat_o) |-> $past(bypass_en_i));

    // R8: a drop without reset is a watchdog loss that restarts negotiation
    a_r8_loss_restarts: assert property (@(posedge clk) disable iff (rst)
        ($fell(link_up_o) && !core_rst_o) |-> (lock_lost_o && an_start_o));

    // R10: loss flag is clear whenever the link comes up
    a_r10_up_clears_loss: assert property (@(posedge clk) disable iff (rst)
        $rose(link_up_o) |-> !lock_lost_o);
endmodule

bind link_supervisor link_supervisor_check u_chk (
    .clk           (clk),
    .rst           (rst),
    .pin_s         (pin_s),
    .state         (state),
    .pwr_good_i    (pwr_good_i),
    .neg_done_i    (neg_done_i),
    .bypass_en_i   (bypass_en_i),
    .core_rst_o    (core_rst_o),
    .an_start_o    (an_start_o),
    .link_up_o     (link_up_o),
    .lock_lost_o   (lock_lost_o),
    .bypass_stat_o (bypass_stat_o)
);

// File: tb/link_supervisor_bench.sv
`timescale 1ns/1ps
module link_supervisor_bench;
    localparam int INIT = 20;
    localparam int IDLE = 12;
    localparam int BYP  = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dis_pin = 1'b1, pwr_good = 1'b1, idle_seen = 1'b0;
    logic neg_done = 1'b0, bypass_en = 1'b0;
    logic core_rst, an_start, link_up, lock_lost, bypass_stat;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    link_supervisor #(
        .SYNC_STAGES(2), .INIT_CYC(INIT), .IDLE_CYC(IDLE), .BYPASS_CYC(BYP)
    ) u_link_supervisor (
        .clk(clk), .rst(rst), .dis_pin_i(dis_pin), .pwr_good_i(pwr_good),
        .idle_seen_i(idle_seen), .neg_done_i(neg_done), .bypass_en_i(bypass_en),
        .core_rst_o(core_rst), .an_start_o(an_start), .link_up_o(link_up),
        .lock_lost_o(lock_lost), .bypass_stat_o(bypass_stat)
    );

    // idle watchdog table: silence after one idle pulse, expected link, expected start pulse
    localparam int NTBL = 5;
    localparam int TBL [NTBL][3] = '{
        '{1,  1, 0},
        '{6,  1, 0},
        '{11, 1, 0},
        '{12, 0, 1},
        '{13, 0, 0}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic pick(input int sel);
        case (sel)
            0: return an_start;
            1: return link_up;
            default: return core_rst;
        endcase
    endfunction

    // counts edges (sampled at negedge) until the selected output is high
    task automatic wait_sig(input int sel, output int n);
        n = 0;
        while (n < 5000) begin
            @(negedge clk);
            n++;
            if (pick(sel)) return;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n, m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 core_rst", core_rst, 1);
        check("R1 an_start", an_start, 0);
        check("R1 link_up", link_up, 0);
        check("R1 lock_lost", lock_lost, 0);
        check("R1 bypass_stat", bypass_stat, 0);
        repeat (10) @(negedge clk);
        check("R1 held pin", core_rst, 1);

        // R11 and R3: pin falls, neg_done held through initialisation
        dis_pin  = 1'b0;
        neg_done = 1'b1;
        repeat (10) @(negedge clk);
        check("R11 no early link", link_up, 0);
        neg_done = 1'b0;
        wait_sig(0, n);
        check("R3 R11 start latency", 10 + n, INIT + 3);
        @(negedge clk);
        check("R3 pulse width", an_start, 0);

        // R7: no bypass, no link
        repeat (BYP + 10) @(negedge clk);
        check("R7 no link without enable", link_up, 0);
        check("R7 still out of reset", core_rst, 0);

        // R5: negotiation done
        neg_done = 1'b1;
        @(negedge clk);
        neg_done = 1'b0;
        check("R5 link up", link_up, 1);
        check("R5 route flag", bypass_stat, 0);

        // R8, R9, R10: idle watchdog table
        for (int i = 0; i < NTBL; i++) begin
            if (!link_up) begin
                neg_done = 1'b1;
                @(negedge clk);
                neg_done = 1'b0;
                check("R10 relink", link_up, 1);
                check("R10 loss cleared", lock_lost, 0);
            end
            idle_seen = 1'b1;
            @(negedge clk);
            idle_seen = 1'b0;
            repeat (TBL[i][0]) @(negedge clk);
            check("R9 R8 link after silence", link_up, TBL[i][1]);
            check("R8 lock_lost", lock_lost, 1 - TBL[i][1]);
            check("R8 restart pulse", an_start, TBL[i][2]);
        end

        // R6: bypass route, after a fresh pin cycle
        bypass_en = 1'b1;
        dis_pin = 1'b1;
        repeat (6) @(negedge clk);
        check("R1 pin reasserted", core_rst, 1);
        check("R10 loss cleared in reset", lock_lost, 0);
        dis_pin = 1'b0;
        wait_sig(0, n);
        check("R3 start latency again", n, INIT + 3);
        wait_sig(1, m);
        check("R6 bypass latency", m, BYP);
        check("R6 route flag", bypass_stat, 1);

        // R2: pin rise drops the link
        dis_pin = 1'b1;
        wait_sig(2, n);
        check("R2 reset latency", n, 3);
        check("R2 link down", link_up, 0);
        check("R2 route flag cleared", bypass_stat, 0);

        // R4: power good controls reset and start
        pwr_good = 1'b0;
        dis_pin  = 1'b0;
        repeat (30) @(negedge clk);
        check("R4 held by power", core_rst, 1);
        pwr_good = 1'b1;
        wait_sig(0, n);
        check("R4 start after power good", n, INIT + 1);
        pwr_good = 1'b0;
        @(negedge clk);
        check("R4 power drop resets", core_rst, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule